// File: doc/BRIEF.md
# LED Status Sequencer with Handoff Wait

This block is a downstream state machine that drives an eight-LED status bank. After reset it lights only the lowest LED and waits until an upstream sequencer pulls an active-low handoff flag low. From then on it runs in whole LED cycles. Each cycle has two phases of equal length.

While the flag stays low, the block runs normal cycles. The lowest LED blinks at a slow period and the upper seven LEDs stay lit. If the flag has returned high, the block runs error cycles instead. The upper and lower nibbles then light in turn at a fast period.

The flag is sampled only when a cycle ends, so a cycle always runs to completion. Phase lengths are counted in pulses of a shared slow time tick. The defaults are 1000 ticks for a normal phase and 122 ticks for an error phase, which with a 1 ms tick gives 1000 ms and 122 ms. The flag comes from another domain and passes through a two-flop synchroniser. The LED outputs are registered and active low.

Top module: `ledStatusSeq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ledN` is 8'hFE. A 0 bit lights an LED and bit 0 is the lowest LED, so only the lowest LED is lit.
- R2: While the synchronised flag is high before the first start, `ledN` stays 8'hFE whatever the tick input does.
- R3: A normal cycle shows 8'h00 (all lit) in its first phase and 8'h01 (lowest LED dark, upper seven lit) in its second phase.
- R4: Each normal phase lasts exactly SLOW_TICKS tick pulses. Counting starts with the first tick after the phase is entered.
- R5: An error cycle shows 8'h0F (upper nibble lit) in its first phase and 8'hF0 (lower nibble lit) in its second phase.
- R6: Each error phase lasts exactly FAST_TICKS tick pulses.
- R7: The flag is examined only when a cycle's second phase ends. A low flag starts a normal cycle and a high flag starts an error cycle. A change in the flag during a cycle does not alter that cycle.
- R8: Asserting reset at any point returns the block to the R1 state and the wait of R2.
- R9: The flag passes through two synchronising flops. If the flag falls while the block is waiting, `ledN` becomes 8'h00 on the third rising clock edge after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse of the shared slow time base |
| flagN | input | 1 | Active-low handoff flag from the upstream sequencer, asynchronous |
| ledN | output | 8 | Registered LED drive, active low |

## Verification
The hardest situation to reach from the ports is a flag edge that lands inside a cycle, one or a few clocks before that cycle's final tick. This is where R7 and the synchroniser latency meet. The random phase uses short phase lengths so that cycles end often, drives sparse random ticks, and toggles the flag at random moments. A cycle-level reference model in the bench predicts the exact LED word on every clock. Directed steps also raise the flag just after a normal cycle has begun, to confirm that the cycle completes and that the next cycle is an error cycle.

// File: rtl/led_seq_pkg.sv
package ledSeqPkg;

  localparam int LED_W = 8;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_NORM_ON,
    PH_NORM_OFF,
    PH_ERR_HI,
    PH_ERR_LO
  } ledPhase_t;

  // strobes from control to the tick timer
  typedef struct packed {
    logic restart;  // hold count at zero
    logic fastSel;  // use the short phase length
  } timerCtrl_t;

  // active-low LED words, bit 0 is the lowest LED
  localparam logic [LED_W-1:0] PAT_WAIT     = 8'hFE;
  localparam logic [LED_W-1:0] PAT_NORM_ON  = 8'h00;
  localparam logic [LED_W-1:0] PAT_NORM_OFF = 8'h01;
  localparam logic [LED_W-1:0] PAT_ERR_HI   = 8'h0F;
  localparam logic [LED_W-1:0] PAT_ERR_LO   = 8'hF0;

endpackage

// File: rtl/led_flag_sync.sv
module ledFlagSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  // resets to the inactive (high) level of the flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/led_tick_timer.sv
module ledTickTimer
  import ledSeqPkg::*;
#(
  parameter int SLOW_TICKS = 1000,
  parameter int FAST_TICKS = 122
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  timerCtrl_t ctrl,
  output logic       phaseDone
);
  localparam int MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt   = ctrl.fastSel ? FAST_LAST : SLOW_LAST;
  assign phaseDone = tick && !ctrl.restart && (tickCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     tickCnt <= '0;
    else if (ctrl.restart)         tickCnt <= '0;
    else if (phaseDone)            tickCnt <= '0;
    else if (tick)                 tickCnt <= tickCnt + 1'b1;
  end
endmodule

// File: rtl/led_seq_ctrl.sv
module ledSeqCtrl
  import ledSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flagSync,
  input  logic             phaseDone,
  output timerCtrl_t       ctrl,
  output logic [LED_W-1:0] ledN
);
  ledPhase_t phase, phaseNxt;
  logic [LED_W-1:0] patNxt;

  always_comb begin
    phaseNxt     = phase;
    ctrl.restart = 1'b0;
    ctrl.fastSel = (phase == PH_ERR_HI) || (phase == PH_ERR_LO);
    case (phase)
      PH_WAIT: begin
        ctrl.restart = 1'b1;
        if (!flagSync) phaseNxt = PH_NORM_ON;
      end
      PH_NORM_ON:  if (phaseDone) phaseNxt = PH_NORM_OFF;
      PH_NORM_OFF: if (phaseDone) phaseNxt = flagSync ? PH_ERR_HI : PH_NORM_ON;
      PH_ERR_HI:   if (phaseDone) phaseNxt = PH_ERR_LO;
      PH_ERR_LO:   if (phaseDone) phaseNxt = flagSync ? PH_ERR_HI : PH_NORM_ON;
      default:     phaseNxt = PH_WAIT;
    endcase
  end

  always_comb begin
    case (phaseNxt)
      PH_NORM_ON:  patNxt = PAT_NORM_ON;
      PH_NORM_OFF: patNxt = PAT_NORM_OFF;
      PH_ERR_HI:   patNxt = PAT_ERR_HI;
      PH_ERR_LO:   patNxt = PAT_ERR_LO;
      default:     patNxt = PAT_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_WAIT;
      ledN  <= PAT_WAIT;
    end else begin
      phase <= phaseNxt;
      ledN  <= patNxt;
    end
  end
endmodule

// File: rtl/led_status_seq.sv
module ledStatusSeq
  import ledSeqPkg::*;
#(
  parameter int SLOW_TICKS = 1000,
  parameter int FAST_TICKS = 122,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             flagN,
  output logic [LED_W-1:0] ledN
);
  logic       flagSync;
  logic       phaseDone;
  timerCtrl_t timerCtrl;

  ledFlagSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(flagN), .syncOut(flagSync)
  );

  ledTickTimer #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) uTimer (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrl(timerCtrl), .phaseDone(phaseDone)
  );

  ledSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .flagSync(flagSync), .phaseDone(phaseDone),
    .ctrl(timerCtrl), .ledN(ledN)
  );
endmodule

// File: rtl/led_status_seq_chk.sv
module ledStatusSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       flagSync,
  input logic [7:0] ledN
);
  // R1
  reset_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> ledN == 8'hFE);

  // R5
  legal_pat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ledN == 8'hFE || ledN == 8'h00 || ledN == 8'h01 || ledN == 8'h0F || ledN == 8'hF0);

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ledN == 8'hFE && flagSync) |=> ledN == 8'hFE);

  // R7
  norm_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ledN) == 8'h00 |-> (ledN == 8'h00 || ledN == 8'h01));

  // R7
  err_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ledN) == 8'h0F |-> (ledN == 8'h0F || ledN == 8'hF0));

  // R3
  norm_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ledN) == 8'h01 |-> (ledN == 8'h01 || ledN == 8'h00 || ledN == 8'h0F));
endmodule

bind ledStatusSeq ledStatusSeqChk uChk (
  .clk(clk), .rstN(rstN), .flagSync(flagSync), .ledN(ledN)
);

// File: tb/tb_ledStatusSeq.sv
module tb_ledStatusSeq;
  localparam int SLOW = 12;
  localparam int FAST = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic flagN = 1'b1;
  logic [7:0] ledN;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ledStatusSeq #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .flagN(flagN), .ledN(ledN)
  );

  // reference model: 0 wait, 1 norm on, 2 norm off, 3 err hi, 4 err lo
  int mPh = 0;
  int mCnt = 0;
  logic s1 = 1'b1, s2 = 1'b1;
  logic [7:0] expLed = 8'hFE;
  bit modelOn = 1'b1;

  function automatic logic [7:0] patOf(int ph);
    case (ph)
      1: return 8'h00;
      2: return 8'h01;
      3: return 8'h0F;
      4: return 8'hF0;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic string reqOf(logic [7:0] p);
    if (p == 8'hFE) return "R2";
    if (p == 8'h00 || p == 8'h01) return "R3";
    return "R5";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; s1 = 1'b1; s2 = 1'b1;
    end else begin
      int lim;
      lim = (mPh >= 3) ? FAST : SLOW;
      if (mPh == 0) begin
        mCnt = 0;
        if (!s2) mPh = 1;
      end else if (tick) begin
        if (mCnt == lim - 1) begin
          mCnt = 0;
          if (mPh == 1) mPh = 2;
          else if (mPh == 3) mPh = 4;
          else mPh = s2 ? 3 : 1;
        end else mCnt = mCnt + 1;
      end
      s2 = s1;
      s1 = flagN;
    end
    expLed = patOf(mPh);
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s ledN actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rstN && modelOn && !finished) check(reqOf(expLed), ledN, expLed);
  end

  task automatic waitPat(logic [7:0] p);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ledN == p) return;
    end
  endtask

  // counts negedges for which ledN keeps pattern p (already showing)
  task automatic runLen(logic [7:0] p, output int n);
    n = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ledN != p) return;
      n++;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    flagN = 1'b1;
    @(negedge clk);
    check("R8", ledN, 8'hFE);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", ledN, 8'hFE);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", ledN, 8'hFE);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", ledN, 8'hFE);

    // R2: ticks while flag high do nothing
    tick = 1'b1;
    repeat (40) @(negedge clk);
    check("R2", ledN, 8'hFE);

    // R9: flag falls, response on third edge
    flagN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9", ledN, 8'hFE);
    @(negedge clk);
    check("R9", ledN, 8'h00);

    // R4: phase lengths with tick every cycle
    runLen(8'h00, n);
    checkInt("R4", n, SLOW);
    runLen(8'h01, n);
    checkInt("R4", n, SLOW);
    check("R3", ledN, 8'h00);

    // R7: raise flag early in a normal cycle; cycle completes
    @(negedge clk);
    flagN = 1'b1;
    repeat (4) @(negedge clk);
    check("R7", ledN, 8'h00);
    waitPat(8'h01);
    check("R7", ledN, 8'h01);
    runLen(8'h01, n);
    check("R7", ledN, 8'h0F);

    // R6: error phase lengths
    runLen(8'h0F, n);
    checkInt("R6", n, FAST);
    runLen(8'hF0, n);
    checkInt("R6", n, FAST);
    check("R5", ledN, 8'h0F);

    // R7: flag low again -> normal after this error cycle
    flagN = 1'b0;
    waitPat(8'hF0);
    runLen(8'hF0, n);
    check("R7", ledN, 8'h00);

    // R8: reset mid-run
    doReset();
    repeat (10) @(negedge clk);
    check("R2", ledN, 8'hFE);

    // R4/R6 under sparse ticks: random stimulus checked by the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick = ($urandom % 3) != 0;
      if (($urandom % 60) == 0) flagN = ~flagN;
      if (i == 3000) doReset();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule